// File: doc/BRIEF.md
# Branch Target PC Update Unit

This block owns a 24-bit program counter and works out where a taken control transfer goes. Each cycle it gets several inputs: the address of the next sequential instruction, a 3-bit mode code, and the operands any mode might use. Those operands are an 8-bit signed displacement, a 24-bit immediate, a 16-bit word-register value, an 8-bit accumulator and a 16-bit data pointer. From these it forms a candidate target, which it drives combinationally so fetch can use it in the same cycle.

Every mode writes a different part of the counter. One adds a displacement over the full width. Three splice immediate bits into the low 11, the low 16 or all 24 bits. One splices a register value into the low 16 bits. One adds the accumulator to the data pointer and places the sum in a fixed top page. When the advance enable is high, the registered PC takes the target if the taken strobe is set and the sequential address if it is not. Decoding, condition evaluation, call stacking and memory access are done elsewhere.

Top module: `bt_pc_unit`

## Requirements
- R1: A synchronous active-high reset loads the PC with 24'hFF0000.
- R2: Mode code 0 (relative) gives the target as next_pc plus the sign-extended 8-bit displacement, modulo 2^24. A carry or borrow may cross a 64 KB boundary, and the whole 24-bit space wraps.
- R3: Mode code 1 (short direct) gives the target as {next_pc[23:11], imm[10:0]}.
- R4: Mode code 2 (region direct) gives the target as {next_pc[23:16], imm[15:0]}.
- R5: Mode code 3 (far direct) gives the full 24-bit immediate as the target.
- R6: Mode code 4 (register indirect) gives the target as {next_pc[23:16], wreg[15:0]}.
- R7: Mode code 5 (accumulator plus pointer) gives the target as {8'hFF, (dptr + zero-extended acc) mod 2^16}. A carry out of bit 15 is dropped.
- R8: Mode codes 6 and 7 give next_pc as the target, so the PC takes the sequential address even when the taken strobe is set.
- R9: While adv_en is low, the PC holds its value whatever the other inputs do.
- R10: On a rising edge with adv_en high, the PC loads the target if take is high and next_pc if take is low.
- R11: tgt_addr shows the target for the current inputs in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Allows a PC update on this edge |
| take | input | 1 | Taken-transfer strobe |
| mode | input | 3 | Target-formation mode code |
| next_pc | input | 24 | Address of the next sequential instruction |
| rel_ofs | input | 8 | Signed displacement |
| imm_tgt | input | 24 | Immediate target bits |
| wreg | input | 16 | Word-register value |
| acc | input | 8 | Accumulator, unsigned |
| dptr | input | 16 | Data pointer |
| tgt_addr | output | 24 | Combinational target |
| pc_q | output | 24 | Registered program counter |

## Verification
The cases that are hardest to reach from the ports are the wrap-arounds. A relative displacement can carry or borrow across a 64 KB boundary, or wrap past the top or bottom of the 24-bit space. The accumulator-plus-pointer sum can overflow 16 bits and must lose its carry and stay in page FFh. The stimulus places next_pc at values such as 0x00FFF0, 0xFFFFFF and 0x000005, and sets dptr to 0xFFF0 with acc at 0xFF. The expected targets are worked out from the arithmetic in the requirements. The bench also changes the operands while adv_en is low and while an unused mode code is selected, then reads pc_q to confirm that nothing was written.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    MODE_REL    = 3'd0,
    MODE_ABS11  = 3'd1,
    MODE_ABS16  = 3'd2,
    MODE_ABS24  = 3'd3,
    MODE_WREG   = 3'd4,
    MODE_ACCPTR = 3'd5,
    MODE_SEQ6   = 3'd6,
    MODE_SEQ7   = 3'd7
  } br_mode_e;
endpackage

// File: rtl/bt_rel_adder.sv
module bt_rel_adder #(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] sum
);
  localparam int EXT_W = ADDR_W - OFS_W;
  logic [ADDR_W-1:0] ofs_ext;
  always_comb begin
    ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
    sum     = base + ofs_ext;
  end
endmodule

// File: rtl/bt_splice.sv
module bt_splice #(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 11
) (
  input  logic [ADDR_W-1:0] upper_src,
  input  logic [LOW_W-1:0]  low_bits,
  output logic [ADDR_W-1:0] merged
);
  generate
    if (LOW_W >= ADDR_W) begin : g_full
      assign merged = low_bits[ADDR_W-1:0];
    end else begin : g_part
      assign merged = {upper_src[ADDR_W-1:LOW_W], low_bits};
    end
  endgenerate
endmodule

// File: rtl/bt_page_adder.sv
module bt_page_adder #(
  parameter int MID_W = 16,
  parameter int ACC_W = 8
) (
  input  logic [MID_W-1:0] ptr,
  input  logic [ACC_W-1:0] acc,
  output logic [MID_W-1:0] sum
);
  localparam int PAD_W = MID_W - ACC_W;
  always_comb sum = ptr + {{PAD_W{1'b0}}, acc};
endmodule

// File: rtl/bt_pc_unit.sv
module bt_pc_unit #(
  parameter int          ADDR_W    = 24,
  parameter int          OFS_W     = 8,
  parameter int          SHORT_W   = 11,
  parameter int          MID_W     = 16,
  parameter int          ACC_W     = 8,
  parameter logic [23:0] RESET_PC  = 24'hFF0000,
  parameter logic [7:0]  HIGH_PAGE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  input  logic              take,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [OFS_W-1:0]  rel_ofs,
  input  logic [ADDR_W-1:0] imm_tgt,
  input  logic [MID_W-1:0]  wreg,
  input  logic [ACC_W-1:0]  acc,
  input  logic [MID_W-1:0]  dptr,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [ADDR_W-1:0] pc_q
);
  import bt_pkg::*;
  localparam int PAGE_W = ADDR_W - MID_W;
  localparam logic [ADDR_W-1:0] PAGE_BASE = {PAGE_W'(HIGH_PAGE), MID_W'(0)};

  logic [ADDR_W-1:0] t_rel, t_abs11, t_abs16, t_wreg, t_accptr;
  logic [MID_W-1:0]  ptr_sum;

  bt_rel_adder #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_rel (
    .base(next_pc), .ofs(rel_ofs), .sum(t_rel));

  bt_splice #(.ADDR_W(ADDR_W), .LOW_W(SHORT_W)) u_abs11 (
    .upper_src(next_pc), .low_bits(imm_tgt[SHORT_W-1:0]), .merged(t_abs11));

  bt_splice #(.ADDR_W(ADDR_W), .LOW_W(MID_W)) u_abs16 (
    .upper_src(next_pc), .low_bits(imm_tgt[MID_W-1:0]), .merged(t_abs16));

  bt_splice #(.ADDR_W(ADDR_W), .LOW_W(MID_W)) u_wreg (
    .upper_src(next_pc), .low_bits(wreg), .merged(t_wreg));

  bt_page_adder #(.MID_W(MID_W), .ACC_W(ACC_W)) u_padd (
    .ptr(dptr), .acc(acc), .sum(ptr_sum));

  bt_splice #(.ADDR_W(ADDR_W), .LOW_W(MID_W)) u_accptr (
    .upper_src(PAGE_BASE), .low_bits(ptr_sum), .merged(t_accptr));

  always_comb begin
    case (br_mode_e'(mode))
      MODE_REL:    tgt_addr = t_rel;
      MODE_ABS11:  tgt_addr = t_abs11;
      MODE_ABS16:  tgt_addr = t_abs16;
      MODE_ABS24:  tgt_addr = imm_tgt;
      MODE_WREG:   tgt_addr = t_wreg;
      MODE_ACCPTR: tgt_addr = t_accptr;
      default:     tgt_addr = next_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= RESET_PC[ADDR_W-1:0];
    else if (adv_en)
      pc_q <= take ? tgt_addr : next_pc;
  end
endmodule

// File: rtl/bt_pc_unit_chk.sv
module bt_pc_unit_chk #(
  parameter int          ADDR_W    = 24,
  parameter int          SHORT_W   = 11,
  parameter int          MID_W     = 16,
  parameter logic [23:0] RESET_PC  = 24'hFF0000,
  parameter logic [7:0]  HIGH_PAGE = 8'hFF
) (
  input logic              clk,
  input logic              rst,
  input logic              adv_en,
  input logic              take,
  input logic [2:0]        mode,
  input logic [ADDR_W-1:0] next_pc,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic [ADDR_W-1:0] pc_q
);
  AST_RESET_VALUE: assert property (@(posedge clk)
    rst |=> pc_q == RESET_PC[ADDR_W-1:0]); // R1

  AST_SHORT_KEEPS_BLOCK: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd1 |-> tgt_addr[ADDR_W-1:SHORT_W] == next_pc[ADDR_W-1:SHORT_W]); // R3

  AST_REGION_KEEPS_PAGE: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd2 |-> tgt_addr[ADDR_W-1:MID_W] == next_pc[ADDR_W-1:MID_W]); // R4

  AST_WREG_KEEPS_PAGE: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd4 |-> tgt_addr[ADDR_W-1:MID_W] == next_pc[ADDR_W-1:MID_W]); // R6

  AST_ACCPTR_TOP_PAGE: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd5 |-> tgt_addr[ADDR_W-1:MID_W] == HIGH_PAGE); // R7

  AST_UNUSED_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    mode[2:1] == 2'b11 |-> tgt_addr == next_pc); // R8

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(pc_q)); // R9

  AST_TAKEN_LOADS_TARGET: assert property (@(posedge clk) disable iff (rst)
    adv_en && take |=> pc_q == $past(tgt_addr)); // R10

  AST_NOT_TAKEN_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    adv_en && !take |=> pc_q == $past(next_pc)); // R10
endmodule

bind bt_pc_unit bt_pc_unit_chk #(
  .ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .MID_W(MID_W),
  .RESET_PC(RESET_PC), .HIGH_PAGE(HIGH_PAGE)
) u_chk (
  .clk(clk), .rst(rst), .adv_en(adv_en), .take(take), .mode(mode),
  .next_pc(next_pc), .tgt_addr(tgt_addr), .pc_q(pc_q)
);

// File: tb/tb_bt_pc_unit.sv
`timescale 1ns/1ps
module tb_bt_pc_unit;
  logic        clk = 1'b0;
  logic        rst, adv_en, take;
  logic [2:0]  mode;
  logic [23:0] next_pc, imm_tgt, tgt_addr, pc_q;
  logic [7:0]  rel_ofs, acc;
  logic [15:0] wreg, dptr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bt_pc_unit dut (
    .clk(clk), .rst(rst), .adv_en(adv_en), .take(take), .mode(mode),
    .next_pc(next_pc), .rel_ofs(rel_ofs), .imm_tgt(imm_tgt), .wreg(wreg),
    .acc(acc), .dptr(dptr), .tgt_addr(tgt_addr), .pc_q(pc_q));

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [2:0] m, input logic [23:0] np,
                        input logic [7:0] o, input logic [23:0] im,
                        input logic [15:0] w, input logic [7:0] a,
                        input logic [15:0] d, input logic tk, input logic en);
    mode = m; next_pc = np; rel_ofs = o; imm_tgt = im;
    wreg = w; acc = a; dptr = d; take = tk; adv_en = en;
  endtask

  // drive at negedge, check combinational target now (R11), PC after edge
  task automatic branch(input string req, input logic [23:0] exp);
    #1;
    chk({req, " tgt R11"}, tgt_addr, exp);
    @(negedge clk);
    chk({req, " pc R10"}, pc_q, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    set_in(3'd3, 24'h123456, 8'h00, 24'hABCDEF, 16'h0, 8'h0, 16'h0, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk);
    chk("R1 reset", pc_q, 24'hFF0000);
    rst = 1'b0;
  endtask

  task automatic t_rel();
    set_in(3'd0, 24'h001000, 8'h10, 24'h0, 16'h0, 8'h0, 16'h0, 1'b1, 1'b1);
    branch("R2 fwd", 24'h001010);
    set_in(3'd0, 24'h001000, 8'h80, 24'h0, 16'h0, 8'h0, 16'h0, 1'b1, 1'b1);
    branch("R2 -128", 24'h000F80);
    set_in(3'd0, 24'h00FFF0, 8'h7F, 24'h0, 16'h0, 8'h0, 16'h0, 1'b1, 1'b1);
    branch("R2 +127 cross 64K", 24'h01006F);
    set_in(3'd0, 24'hFFFFFF, 8'h01, 24'h0, 16'h0, 8'h0, 16'h0, 1'b1, 1'b1);
    branch("R2 wrap top", 24'h000000);
    set_in(3'd0, 24'h000005, 8'hF0, 24'h0, 16'h0, 8'h0, 16'h0, 1'b1, 1'b1);
    branch("R2 wrap bottom", 24'hFFFFF5);
  endtask

  task automatic t_abs11();
    set_in(3'd1, 24'h3A5FFF, 8'h00, 24'hFFF123, 16'h0, 8'h0, 16'h0, 1'b1, 1'b1);
    branch("R3 short", 24'h3A5923);
    set_in(3'd1, 24'h000800, 8'h00, 24'h0007FF, 16'h0, 8'h0, 16'h0, 1'b1, 1'b1);
    branch("R3 block top", 24'h000FFF);
  endtask

  task automatic t_abs16();
    set_in(3'd2, 24'h7E1234, 8'h00, 24'h55BEEF, 16'h0, 8'h0, 16'h0, 1'b1, 1'b1);
    branch("R4 region", 24'h7EBEEF);
  endtask

  task automatic t_abs24();
    set_in(3'd3, 24'h000010, 8'h00, 24'hFFFFFF, 16'h0, 8'h0, 16'h0, 1'b1, 1'b1);
    branch("R5 far max", 24'hFFFFFF);
    set_in(3'd3, 24'hABCDEF, 8'h00, 24'h000000, 16'h0, 8'h0, 16'h0, 1'b1, 1'b1);
    branch("R5 far zero", 24'h000000);
  endtask

  task automatic t_wreg();
    set_in(3'd4, 24'hC3FFFE, 8'h00, 24'h999999, 16'h0042, 8'h0, 16'h0, 1'b1, 1'b1);
    branch("R6 wreg", 24'hC30042);
  endtask

  task automatic t_accptr();
    set_in(3'd5, 24'h010000, 8'h00, 24'h0, 16'h0, 8'h34, 16'h1200, 1'b1, 1'b1);
    branch("R7 sum", 24'hFF1234);
    set_in(3'd5, 24'h010000, 8'h00, 24'h0, 16'h0, 8'hFF, 16'hFFF0, 1'b1, 1'b1);
    branch("R7 carry dropped", 24'hFF00EF);
    set_in(3'd5, 24'h010000, 8'h00, 24'h0, 16'h0, 8'h80, 16'h0000, 1'b1, 1'b1);
    branch("R7 acc unsigned", 24'hFF0080);
  endtask

  task automatic t_unused();
    set_in(3'd6, 24'h224466, 8'h7F, 24'hFFFFFF, 16'hFFFF, 8'hFF, 16'hFFFF, 1'b1, 1'b1);
    branch("R8 code6", 24'h224466);
    set_in(3'd7, 24'h335577, 8'h80, 24'h000000, 16'h1111, 8'h11, 16'h1111, 1'b1, 1'b1);
    branch("R8 code7", 24'h335577);
  endtask

  task automatic t_hold();
    set_in(3'd3, 24'h0A0A0A, 8'h00, 24'h5A5A5A, 16'h0, 8'h0, 16'h0, 1'b1, 1'b1);
    branch("R9 setup", 24'h5A5A5A);
    set_in(3'd3, 24'h111111, 8'h00, 24'h777777, 16'h0, 8'h0, 16'h0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R9 hold taken", pc_q, 24'h5A5A5A);
    set_in(3'd0, 24'h222222, 8'h05, 24'h0, 16'h0, 8'h0, 16'h0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R9 hold seq", pc_q, 24'h5A5A5A);
  endtask

  task automatic t_seq();
    set_in(3'd3, 24'h400004, 8'h00, 24'hDEAD00, 16'h0, 8'h0, 16'h0, 1'b0, 1'b1);
    #1;
    chk("R11 tgt while not taken", tgt_addr, 24'hDEAD00);
    @(negedge clk);
    chk("R10 not taken", pc_q, 24'h400004);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    set_in(3'd0, 24'h0, 8'h0, 24'h0, 16'h0, 8'h0, 16'h0, 1'b0, 1'b0);
    @(negedge clk);
    t_reset();
    t_rel();
    t_abs11();
    t_abs16();
    t_abs24();
    t_wreg();
    t_accptr();
    t_unused();
    t_hold();
    t_seq();
    t_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule